// File: doc/BRIEF.md
# Multi-Device Read Latency Aligner

This block sits in the read datapath behind several memory devices whose round-trip read latencies differ. Calibration logic supplies one measured latency per device. The block works out a common final latency and gives each device's return data enough extra delay to reach it. Once that is done, every read returns on all devices in the same cycle. The extra delay comes from a small register-array buffer per device. The buffer is written at a free-running write pointer, and the read side sits a fixed number of entries behind that pointer.

By default the common latency is the slowest device's latency. In fixed-latency mode the caller requests a target instead. The block accepts the target only if every device can be delayed up to it within its buffer. If it cannot, the block reports that and falls back to the slowest device. In default mode the block also flags a spread between the fastest and slowest device that is larger than two cycles.

The block delays the read-issue strobe by the final latency to produce a read-data-valid strobe. That strobe is allowed out only while the calibration-done input is high. The settings follow the latency and mode inputs while calibration runs, and are frozen as soon as calibration-done goes high.

Top module: `rd_lat_aligner`

## Requirements
- R1: With fixed-latency mode off, the final latency equals the largest of the measured latencies, and the target-ok output is 0.
- R2: With fixed-latency mode on, a target T is accepted when T is at least the largest measured latency and T minus the smallest measured latency is at most BUF_DEPTH. The final latency is then T and target-ok is 1. The boundary T minus smallest equal to BUF_DEPTH is accepted.
- R3: With fixed-latency mode on, a target that fails either R2 condition gives target-ok 0, and the final latency is the largest measured latency.
- R4: The skew error output is 1 exactly when fixed-latency mode is off and the largest minus the smallest measured latency exceeds 2. It is always 0 in fixed-latency mode.
- R5: Device i's read data is presented on bits [i*DATA_W +: DATA_W] of the data input, and its measured latency on bits [i*LAT_W +: LAT_W] of the latency input. A word presented in cycle c appears on the same bits of the data output in cycle c + final latency - latency(i). A device with no extra delay passes through in the same cycle.
- R6: The read-data-valid output is 1 in cycle c + final latency exactly when the read-issue strobe was 1 in cycle c, given that calibration-done is 1 in the later cycle. With a final latency of 0 it follows the strobe in the same cycle.
- R7: The read-data-valid output is 0 in every cycle in which calibration-done is 0, whatever the read-issue strobe did.
- R8: While calibration-done is 0, the settings (final latency, target-ok, skew error and the per-device delays) take the values computed from the current inputs one clock edge later. While calibration-done is 1, changes to the latency, mode and target inputs have no effect on them.
- R9: After reset, the final latency is 0, target-ok is 0, skew error is 0 and read-data-valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration finished; freezes settings and enables valid |
| det_en | input | 1 | Fixed-latency mode enable |
| det_target | input | LAT_W | Requested latency in fixed-latency mode |
| lat_meas | input | NUM_DEV*LAT_W | Measured latency per device |
| rd_issue | input | 1 | Read-issue strobe |
| rd_data_in | input | NUM_DEV*DATA_W | Raw read data per device |
| rd_data_out | output | NUM_DEV*DATA_W | Aligned read data per device |
| rd_valid | output | 1 | Aligned read data valid |
| final_lat | output | LAT_W | Final read latency in clock cycles |
| target_ok | output | 1 | Requested fixed latency was achievable |
| skew_err | output | 1 | Device latency spread exceeds two cycles in default mode |

## Verification
Settings show up one rising edge after the inputs change while calibration-done is low. The bench waits out that edge and then reads the settings at the next falling edge. An aligned read is due on both the data and valid outputs exactly final-latency cycles after its issue strobe. The driver stamps each issued read with that due cycle and pushes it into a queue. A device model replays the read's tag on each device after that device's own latency. The monitor compares at every falling edge, and it reports a read that arrives early, arrives late or never arrives, as well as wrong data on any device.

// File: rtl/rla_pkg.sv
package rla_pkg;

    localparam int LAT_W      = 5;
    localparam int LAT_SPAN   = 1 << LAT_W;
    localparam int SKEW_LIMIT = 2;

    typedef logic [LAT_W-1:0] lat_t;

    typedef struct packed {
        lat_t final_lat;
        logic target_ok;
        logic skew_err;
    } align_cfg_t;

    function automatic lat_t lat_gap(input lat_t hi, input lat_t lo);
        return (hi >= lo) ? lat_t'(hi - lo) : '0;
    endfunction

endpackage

// File: rtl/rla_planner.sv
module rla_planner
    import rla_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int BUF_DEPTH = 8,
    parameter int DLY_W     = 4
) (
    input  logic [NUM_DEV*LAT_W-1:0] lat_meas_i,
    input  logic                     det_en_i,
    input  lat_t                     det_target_i,
    output align_cfg_t               cfg_o,
    output logic [NUM_DEV*DLY_W-1:0] delay_o
);

    localparam lat_t DEPTH_L = lat_t'(BUF_DEPTH);

    lat_t lat_hi, lat_lo, spread;
    logic reach_ok;

    always_comb begin
        lat_hi = '0;
        lat_lo = '1;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (lat_meas_i[i*LAT_W +: LAT_W] > lat_hi) lat_hi = lat_meas_i[i*LAT_W +: LAT_W];
            if (lat_meas_i[i*LAT_W +: LAT_W] < lat_lo) lat_lo = lat_meas_i[i*LAT_W +: LAT_W];
        end
        spread   = lat_gap(lat_hi, lat_lo);
        reach_ok = (det_target_i >= lat_hi) && (lat_gap(det_target_i, lat_lo) <= DEPTH_L);

        cfg_o.target_ok = det_en_i && reach_ok;
        cfg_o.final_lat = cfg_o.target_ok ? det_target_i : lat_hi;
        cfg_o.skew_err  = !det_en_i && (spread > lat_t'(SKEW_LIMIT));

        for (int i = 0; i < NUM_DEV; i++) begin
            if (lat_gap(cfg_o.final_lat, lat_meas_i[i*LAT_W +: LAT_W]) > DEPTH_L)
                delay_o[i*DLY_W +: DLY_W] = DLY_W'(BUF_DEPTH);
            else
                delay_o[i*DLY_W +: DLY_W] =
                    DLY_W'(lat_gap(cfg_o.final_lat, lat_meas_i[i*LAT_W +: LAT_W]));
        end
    end

endmodule

// File: rtl/rla_delay_line.sv
module rla_delay_line #(
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 8,
    parameter int DLY_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [DLY_W-1:0]  dly,
    output logic [DATA_W-1:0] dout
);

    localparam int AW = $clog2(BUF_DEPTH);

    logic [DATA_W-1:0] store [BUF_DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < BUF_DEPTH; i++) store[i] <= '0;
        end else begin
            store[wr_ptr] <= din;
            wr_ptr        <= wr_ptr + 1'b1;
        end
    end

    // Read side trails the write pointer by the programmed delay.
    assign rd_ptr = wr_ptr - dly[AW-1:0];
    assign dout   = (dly == '0) ? din : store[rd_ptr];

endmodule

// File: rtl/rla_valid_pipe.sv
module rla_valid_pipe
    import rla_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  lat_t lat_i,
    input  logic enable_i,
    output logic valid_o
);

    localparam int SH_W = LAT_SPAN - 1;

    logic [SH_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[SH_W-2:0], issue_i};
    end

    assign valid_o = enable_i && ((lat_i == '0) ? issue_i : hist[lat_i - 1'b1]);

endmodule

// File: rtl/rd_lat_aligner.sv
module rd_lat_aligner
    import rla_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cal_done,
    input  logic                      det_en,
    input  logic [LAT_W-1:0]          det_target,
    input  logic [NUM_DEV*LAT_W-1:0]  lat_meas,
    input  logic                      rd_issue,
    input  logic [NUM_DEV*DATA_W-1:0] rd_data_in,
    output logic [NUM_DEV*DATA_W-1:0] rd_data_out,
    output logic                      rd_valid,
    output logic [LAT_W-1:0]          final_lat,
    output logic                      target_ok,
    output logic                      skew_err
);

    localparam int DLY_W = $clog2(BUF_DEPTH + 1);

    align_cfg_t               cfg_next, cfg_q;
    logic [NUM_DEV*DLY_W-1:0] dly_next, dly_q;

    rla_planner #(
        .NUM_DEV  (NUM_DEV),
        .BUF_DEPTH(BUF_DEPTH),
        .DLY_W    (DLY_W)
    ) u_plan (
        .lat_meas_i  (lat_meas),
        .det_en_i    (det_en),
        .det_target_i(det_target),
        .cfg_o       (cfg_next),
        .delay_o     (dly_next)
    );

    // Settings track the inputs during calibration, then hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            dly_q <= '0;
        end else if (!cal_done) begin
            cfg_q <= cfg_next;
            dly_q <= dly_next;
        end
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        rla_delay_line #(
            .DATA_W   (DATA_W),
            .BUF_DEPTH(BUF_DEPTH),
            .DLY_W    (DLY_W)
        ) u_dly (
            .clk (clk),
            .rst (rst),
            .din (rd_data_in[g*DATA_W +: DATA_W]),
            .dly (dly_q[g*DLY_W +: DLY_W]),
            .dout(rd_data_out[g*DATA_W +: DATA_W])
        );
    end

    rla_valid_pipe u_vld (
        .clk     (clk),
        .rst     (rst),
        .issue_i (rd_issue),
        .lat_i   (cfg_q.final_lat),
        .enable_i(cal_done),
        .valid_o (rd_valid)
    );

    assign final_lat = cfg_q.final_lat;
    assign target_ok = cfg_q.target_ok;
    assign skew_err  = cfg_q.skew_err;

endmodule

// File: rtl/rd_lat_aligner_chk.sv
module rd_lat_aligner_chk
    import rla_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cal_done,
    input logic             det_en,
    input logic [LAT_W-1:0] det_target,
    input logic             rd_issue,
    input logic             rd_valid,
    input logic [LAT_W-1:0] final_lat,
    input logic             target_ok,
    input logic             skew_err
);

    logic started, live, live2;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        live    <= !rst;
        live2   <= live && !rst;
    end

    assert_reset_state_R9: assert property (@(posedge clk)
        (started && $past(rst)) |-> (final_lat == '0 && !target_ok && !skew_err && !rd_valid));

    assert_valid_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> !rd_valid);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (live2 && $past(cal_done)) |-> ($stable(final_lat) && $stable(target_ok) && $stable(skew_err)));

    assert_default_no_ok_R1: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!cal_done) && $past(!det_en)) |-> !target_ok);

    assert_ok_uses_target_R2: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!cal_done) && target_ok) |-> ($past(det_en) && final_lat == $past(det_target)));

    assert_no_skew_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!cal_done) && $past(det_en)) |-> !skew_err);

    assert_zero_lat_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (cal_done && final_lat == '0) |-> (rd_valid == rd_issue));

endmodule

bind rd_lat_aligner rd_lat_aligner_chk u_chk (.*);

// File: tb/rd_lat_aligner_test.sv
module rd_lat_aligner_test;
    import rla_pkg::*;

    localparam int NDEV  = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cal_done = 1'b0;
    logic                 det_en = 1'b0;
    logic [LAT_W-1:0]     det_target = '0;
    logic [NDEV*LAT_W-1:0] lat_meas = '0;
    logic                 rd_issue = 1'b0;
    logic [NDEV*DW-1:0]   rd_data_in = '0;
    logic [NDEV*DW-1:0]   rd_data_out;
    logic                 rd_valid;
    logic [LAT_W-1:0]     final_lat;
    logic                 target_ok;
    logic                 skew_err;

    rd_lat_aligner #(.NUM_DEV(NDEV), .DATA_W(DW), .BUF_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cal_done(cal_done), .det_en(det_en),
        .det_target(det_target), .lat_meas(lat_meas), .rd_issue(rd_issue),
        .rd_data_in(rd_data_in), .rd_data_out(rd_data_out), .rd_valid(rd_valid),
        .final_lat(final_lat), .target_ok(target_ok), .skew_err(skew_err)
    );

    always #10 clk = ~clk;

    typedef struct { int due; logic [5:0] tag; } exp_t;

    exp_t           sb[$];
    logic [DW-1:0]  sched [NDEV][64];
    int             dev_lat [NDEV];
    int             cyc = 0;
    int             checks = 0;
    int             errors = 0;
    int             exp_final;
    logic           exp_ok, exp_skew;
    logic [5:0]     tag_ctr = '0;
    logic           mon_en = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic set_model(input int l0, input int l1, input int l2, input int l3,
                             input bit det, input int tgt);
        int mx, mn;
        dev_lat[0] = l0; dev_lat[1] = l1; dev_lat[2] = l2; dev_lat[3] = l3;
        mx = 0; mn = 1000;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_lat[i] > mx) mx = dev_lat[i];
            if (dev_lat[i] < mn) mn = dev_lat[i];
        end
        exp_ok    = det && (tgt >= mx) && (tgt - mn <= DEPTH);
        exp_final = exp_ok ? tgt : mx;
        exp_skew  = !det && (mx - mn > 2);
    endtask

    task automatic drive_cycle(input bit issue);
        @(posedge clk);
        #1;
        if (issue) begin
            tag_ctr = tag_ctr + 6'd1;
            for (int i = 0; i < NDEV; i++)
                sched[i][(cyc + dev_lat[i]) % 64] = {tag_ctr, 2'(i)};
            if (cal_done) begin
                exp_t e;
                e.due = cyc + exp_final;
                e.tag = tag_ctr;
                sb.push_back(e);
            end
        end
        rd_issue = issue;
        for (int i = 0; i < NDEV; i++) begin
            rd_data_in[i*DW +: DW] = sched[i][cyc % 64];
            sched[i][cyc % 64] = 8'hA5;
        end
    endtask

    // Monitor: compares aligned outputs with the scoreboard each cycle.
    always @(negedge clk) begin
        if (mon_en) begin
            if (!cal_done)
                check(!rd_valid, "R7", "valid while calibration pending", int'(rd_valid), 0);
            if (rd_valid) begin
                if (sb.size() == 0 || sb[0].due != cyc) begin
                    check(1'b0, "R6", "unexpected valid, due cycle",
                          cyc, (sb.size() == 0) ? -1 : sb[0].due);
                end else begin
                    check(1'b1, "R6", "valid on time", cyc, sb[0].due);
                    for (int i = 0; i < NDEV; i++)
                        check(rd_data_out[i*DW +: DW] == {sb[0].tag, 2'(i)}, "R5",
                              $sformatf("device %0d aligned data", i),
                              int'(rd_data_out[i*DW +: DW]), int'({sb[0].tag, 2'(i)}));
                    void'(sb.pop_front());
                end
            end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                check(1'b0, "R6", "missing valid, due cycle", cyc, sb[0].due);
                void'(sb.pop_front());
            end
        end
    end

    task automatic check_cfg(input string req);
        @(negedge clk);
        check(int'(final_lat) == exp_final, req, "final latency", int'(final_lat), exp_final);
        check(target_ok == exp_ok, req, "target ok", int'(target_ok), int'(exp_ok));
        check(skew_err == exp_skew, "R4", "skew error", int'(skew_err), int'(exp_skew));
    endtask

    // Calibration window: program inputs, idle long enough to flush pending strobes.
    task automatic calibrate(input int l0, input int l1, input int l2, input int l3,
                             input bit det, input int tgt, input string req);
        @(posedge clk);
        #1;
        cal_done   = 1'b0;
        lat_meas   = {LAT_W'(l3), LAT_W'(l2), LAT_W'(l1), LAT_W'(l0)};
        det_en     = det;
        det_target = LAT_W'(tgt);
        set_model(l0, l1, l2, l3, det, tgt);
        for (int k = 0; k < 36; k++) drive_cycle(k < 4);
        check_cfg(req);
        @(posedge clk);
        #1;
        cal_done = 1'b1;
    endtask

    task automatic stream(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            case (mode)
                0:       drive_cycle(1'b1);
                1:       drive_cycle(k % 3 == 0);
                default: drive_cycle(((k * 7 + 3) % 5) < 2);
            endcase
        end
        for (int k = 0; k < 40; k++) drive_cycle(1'b0);
        @(negedge clk);
        check(sb.size() == 0, "R6", "reads left undelivered", sb.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < NDEV; i++)
            for (int s = 0; s < 64; s++) sched[i][s] = 8'hA5;
        for (int i = 0; i < NDEV; i++) dev_lat[i] = 0;
        exp_final = 0; exp_ok = 1'b0; exp_skew = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(final_lat == '0, "R9", "reset final latency", int'(final_lat), 0);
        check(!target_ok, "R9", "reset target ok", int'(target_ok), 0);
        check(!skew_err, "R9", "reset skew error", int'(skew_err), 0);
        check(!rd_valid, "R9", "reset valid", int'(rd_valid), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        mon_en = 1'b1;

        // R1: default mode, spread of exactly 2 is not an error
        calibrate(5, 6, 7, 5, 1'b0, 0, "R1");
        stream(30, 0);

        // R8: inputs change while calibration is done; settings hold
        @(posedge clk);
        #1;
        lat_meas = {LAT_W'(1), LAT_W'(2), LAT_W'(3), LAT_W'(20)};
        det_en = 1'b1;
        det_target = LAT_W'(25);
        repeat (3) drive_cycle(1'b0);
        check_cfg("R8");
        stream(20, 2);

        // R4: default mode, spread 3 flags an error but still aligns
        calibrate(3, 6, 4, 3, 1'b0, 0, "R1");
        stream(25, 1);

        // R2: reachable fixed target
        calibrate(5, 6, 7, 5, 1'b1, 12, "R2");
        stream(25, 2);

        // R2 boundary: target minus smallest equals depth
        calibrate(5, 6, 7, 5, 1'b1, 13, "R2");
        stream(25, 0);

        // R3: one beyond the buffer reach
        calibrate(5, 6, 7, 5, 1'b1, 14, "R3");
        stream(20, 1);

        // R3: target below the slowest device
        calibrate(5, 6, 7, 5, 1'b1, 6, "R3");
        stream(20, 2);

        // R2: target equal to slowest, wide spread, no skew error in fixed mode
        calibrate(2, 9, 4, 2, 1'b1, 9, "R2");
        stream(25, 0);

        // R5/R6: zero latency everywhere, pass-through and same-cycle valid
        calibrate(0, 0, 0, 0, 1'b0, 0, "R1");
        stream(25, 0);

        // R4: default mode, spread of a full buffer depth
        calibrate(1, 9, 4, 2, 1'b0, 0, "R1");
        stream(25, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule